// File: doc/BRIEF.md
# Graphics DMA Region Protection Checker

This block decides, for each address that a graphics DMA engine presents, whether the access falls into a protected part of memory. Four memories are covered: two 128 MB main-memory banks, a small fast internal RAM, and a 4 MB auxiliary memory. Each cutoff protects the top part of its memory, from a computed boundary up to that memory's end. Small fields in one protection word set the boundaries, and the boundary moves down in fixed steps. A non-zero cutoff on the lower main bank also locks the first 8 MB of the upper main bank.

Software loads the protection word through a plain write port and can read it back at any time. The address side is a valid strobe with an address. There is no ready signal: the checker accepts one address every cycle and never applies back-pressure. Each accepted address produces a blocked/allowed verdict one cycle later, marked by its own valid flag. The verdict uses the protection word that was in effect in the cycle the address was presented.

Top module: `dma_guard`

## Requirements
- R1: After reset the protection word reads 0, and `res_valid` and `res_blocked` are both 0.
- R2: A write stores bits 10:0 of `cfg_wdata`. Bits 31:11 always read back as 0 whatever was written, and the word holds its value while `cfg_we` is low.
- R3: `res_valid` is `req_valid` delayed by one clock. `res_blocked` is 0 whenever `res_valid` is 0. An address is judged against the protection word as it stood before any write in the same cycle.
- R4: Lower main bank (0x20000000–0x27FFFFFF), field n in bits 3:0. When n is not 0, addresses from 0x28000000 − n·0x800000 up to 0x27FFFFFF are blocked. When n is 0, nothing in this bank is blocked.
- R5: Addresses 0x20000000–0x207FFFFF are never blocked, for any protection word.
- R6: Upper main bank (0x28000000–0x2FFFFFFF), field m in bits 7:4. When m is not 0, addresses from 0x30000000 − m·0x800000 up to 0x2FFFFFFF are blocked.
- R7: When bits 3:0 are non-zero, addresses 0x28000000–0x287FFFFF are also blocked. This combines with any R6 range.
- R8: Fast RAM window 0x1FF80000–0x1FFFFFFF: the whole window is blocked when bit 8 is 1 and is open when bit 8 is 0.
- R9: Auxiliary memory (0x1F000000–0x1F3FFFFF), field k in bits 10:9. When k is not 0, addresses from 0x1F400000 − k·0x100000 up to 0x1F3FFFFF are blocked.
- R10: With a protection word of 0, no address is blocked. Addresses outside the four memories are never blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the protection word |
| cfg_wdata | input | 32 | Write data for the protection word |
| cfg_rdata | output | 32 | Current protection word |
| req_valid | input | 1 | Address strobe, accepted every cycle |
| req_addr | input | 32 | DMA access address |
| res_valid | output | 1 | Verdict valid, one cycle after `req_valid` |
| res_blocked | output | 1 | 1 when the judged access is protected |

## Verification
The bench sweeps every value of both main-bank fields, and combines them with every fast-RAM and auxiliary setting. For each protection word it probes the first and last byte of every step-sized chunk in all four memories, plus the addresses just outside them. This catches an off-by-one boundary, which would block or release a whole 8 MB or 1 MB chunk at the edge. It also catches a wrong field slice, which would move a region's boundary by the wrong number of steps, and a missing or always-on 8 MB lock at the bottom of the upper bank. A directed case presents an address in the same cycle as a write: a design that forwards the new word would block one cycle too early. Writing all ones exposes reserved bits that were stored instead of read back as 0.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [31:0] CFG_MASK = 32'h0000_07FF;

  typedef struct packed {
    logic [20:0] rsvd;
    logic [1:0]  aux_n;
    logic        fast_lock;
    logic [3:0]  hi_n;
    logic [3:0]  lo_n;
  } prot_word_t;
endpackage

// File: rtl/dmag_cfg_reg.sv
module dmag_cfg_reg
  import dmag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output prot_word_t        word
);
  prot_word_t word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   word_q <= '0;
    else if (we)  word_q <= prot_word_t'(wdata & CFG_MASK);
  end

  assign word = word_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(word_q));
  assert_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (word_q.rsvd == '0));
endmodule

// File: rtl/dmag_cut.sv
module dmag_cut #(
  parameter logic [31:0] TOP  = 32'h2800_0000,
  parameter logic [31:0] STEP = 32'h0080_0000,
  parameter int unsigned FW   = 4
) (
  input  logic [FW-1:0] n,
  input  logic [31:0]   addr,
  output logic          hit
);
  logic [31:0] floor_addr;

  always_comb begin
    floor_addr = TOP - (32'(n) * STEP);
    hit = (n != '0) && (addr >= floor_addr) && (addr < TOP);
  end
endmodule

// File: rtl/dmag_window.sv
module dmag_window #(
  parameter logic [31:0] BASE = 32'h1FF8_0000,
  parameter logic [32:0] SIZE = 33'h0_0008_0000
) (
  input  logic        en,
  input  logic [31:0] addr,
  output logic        hit
);
  localparam logic [32:0] LIMIT = {1'b0, BASE} + SIZE;

  assign hit = en && ({1'b0, addr} >= {1'b0, BASE}) && ({1'b0, addr} < LIMIT);
endmodule

// File: rtl/dma_guard.sv
module dma_guard
  import dmag_pkg::*;
#(
  parameter logic [31:0] LO_TOP    = 32'h2800_0000,
  parameter logic [31:0] HI_TOP    = 32'h3000_0000,
  parameter logic [31:0] MAIN_STEP = 32'h0080_0000,
  parameter logic [31:0] AUX_TOP   = 32'h1F40_0000,
  parameter logic [31:0] AUX_STEP  = 32'h0010_0000,
  parameter logic [31:0] FAST_BASE = 32'h1FF8_0000,
  parameter logic [32:0] FAST_SIZE = 33'h0_0008_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        res_valid,
  output logic        res_blocked
);
  localparam int unsigned NHIT = 5;

  prot_word_t      word;
  logic [NHIT-1:0] hits;
  logic            any_hit;

  dmag_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .word(word)
  );

  dmag_cut #(.TOP(LO_TOP), .STEP(MAIN_STEP), .FW(4)) u_lo (
    .n(word.lo_n), .addr(req_addr), .hit(hits[0])
  );
  dmag_cut #(.TOP(HI_TOP), .STEP(MAIN_STEP), .FW(4)) u_hi (
    .n(word.hi_n), .addr(req_addr), .hit(hits[1])
  );
  dmag_window #(.BASE(LO_TOP), .SIZE({1'b0, MAIN_STEP})) u_hi_floor (
    .en(word.lo_n != 4'd0), .addr(req_addr), .hit(hits[2])
  );
  dmag_window #(.BASE(FAST_BASE), .SIZE(FAST_SIZE)) u_fast (
    .en(word.fast_lock), .addr(req_addr), .hit(hits[3])
  );
  dmag_cut #(.TOP(AUX_TOP), .STEP(AUX_STEP), .FW(2)) u_aux (
    .n(word.aux_n), .addr(req_addr), .hit(hits[4])
  );

  assign any_hit   = |hits;
  assign cfg_rdata = word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_blocked <= 1'b0;
    end else begin
      res_valid   <= req_valid;
      res_blocked <= req_valid && any_hit;
    end
  end

  assert_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_blocked);
  assert_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cfg_rdata == 32'd0) |=> !res_blocked);
  assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:23] == 9'h040) |=> !res_blocked);
endmodule

// File: tb/dma_guard_test.sv
`timescale 1ns/1ps
module dma_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        res_valid;
  logic        res_blocked;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_guard uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
    .res_valid(res_valid), .res_blocked(res_blocked)
  );

  function automatic bit expect_block(input logic [31:0] c, input logic [31:0] a);
    logic [31:0] x, y, z;
    x = 32'(c[3:0]); y = 32'(c[7:4]); z = 32'(c[10:9]);
    if (a >= 32'h2000_0000 && a < 32'h2800_0000)
      return (x != 0) && (a >= 32'h2800_0000 - x * 32'h80_0000);
    if (a >= 32'h2800_0000 && a < 32'h3000_0000)
      return ((y != 0) && (a >= 32'h3000_0000 - y * 32'h80_0000)) ||
             ((x != 0) && (a < 32'h2880_0000));
    if (a >= 32'h1FF8_0000 && a < 32'h2000_0000) return c[8];
    if (a >= 32'h1F00_0000 && a < 32'h1F40_0000)
      return (z != 0) && (a >= 32'h1F40_0000 - z * 32'h10_0000);
    return 1'b0;
  endfunction

  function automatic string tag_of(input logic [31:0] a);
    if (a >= 32'h2000_0000 && a < 32'h2080_0000) return "R5";
    if (a >= 32'h2000_0000 && a < 32'h2800_0000) return "R4";
    if (a >= 32'h2800_0000 && a < 32'h2880_0000) return "R7";
    if (a >= 32'h2800_0000 && a < 32'h3000_0000) return "R6";
    if (a >= 32'h1FF8_0000 && a < 32'h2000_0000) return "R8";
    if (a >= 32'h1F00_0000 && a < 32'h1F40_0000) return "R9";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic probe(input logic [31:0] c, input logic [31:0] a);
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
    check("R3 valid", 32'(res_valid), 32'd1);
    check(tag_of(a), 32'(res_blocked), 32'(expect_block(c, a)));
  endtask

  task automatic sweep(input logic [31:0] c);
    for (int k = 0; k < 16; k++) begin
      probe(c, 32'h2000_0000 + k * 32'h80_0000);
      probe(c, 32'h2000_0000 + (k + 1) * 32'h80_0000 - 1);
      probe(c, 32'h2800_0000 + k * 32'h80_0000);
      probe(c, 32'h2800_0000 + (k + 1) * 32'h80_0000 - 1);
    end
    for (int k = 0; k < 4; k++) begin
      probe(c, 32'h1F00_0000 + k * 32'h10_0000);
      probe(c, 32'h1F00_0000 + (k + 1) * 32'h10_0000 - 1);
    end
    probe(c, 32'h1FF8_0000); probe(c, 32'h1FFF_FFFF);
    probe(c, 32'h1FF7_FFFF); probe(c, 32'h3000_0000);
    probe(c, 32'h1EFF_FFFF); probe(c, 32'h0000_0000); probe(c, 32'hFFFF_FFFF);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 word", cfg_rdata, 32'd0);
    check("R1 valid", 32'(res_valid), 32'd0);
    check("R1 blocked", 32'(res_blocked), 32'd0);

    write_cfg(32'hFFFF_FFFF);
    check("R2 mask ones", cfg_rdata, 32'h0000_07FF);
    repeat (3) @(negedge clk);
    check("R2 hold", cfg_rdata, 32'h0000_07FF);
    write_cfg(32'hFFFF_F800);
    check("R2 rsvd only", cfg_rdata, 32'd0);

    sweep(32'd0);  // R10 open word

    // R3: same-cycle write is not seen by the request
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'h0000_000F;
    req_valid = 1'b1; req_addr = 32'h27FF_FFFF;
    @(negedge clk); cfg_we = 1'b0; req_valid = 1'b0;
    check("R3 old word", 32'(res_blocked), 32'd0);
    @(negedge clk);
    check("R3 idle valid", 32'(res_valid), 32'd0);
    check("R3 idle blocked", 32'(res_blocked), 32'd0);
    probe(32'h0000_000F, 32'h27FF_FFFF);

    for (int i = 0; i < 256; i++) begin
      logic [31:0] c;
      c = 32'(i);
      c[8] = c[0] ^ c[4];
      c[10:9] = c[2:1] ^ c[6:5];
      write_cfg(c | 32'hABCD_E800);
      check("R2 readback", cfg_rdata, c);
      sweep(c);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule